// File: doc/BRIEF.md
# Set-Associative TLB Command Engine

This block is a joint translation buffer for a processor MMU, driven through a small register-mapped command interface. System software loads a first page-descriptor register with a virtual page, an address-space identifier and attribute bits. It loads a second page-descriptor register with the frame and permission word, and an index register with a linear entry number. It then writes a command code. The engine searches the ways of one set, fills or reads back entries, picks free slots and pulses an invalidate line to the micro-TLBs.

Entries sit in `SETS` sets of `WAYS` ways, 128 by 4 by default. A linear index is set times `WAYS` plus way, so the ways of one set are neighbours. Probe results come back in the index register. Besides a plain miss, a probe can return a separate code when two or more ways of the set match at once. That case can only come from software installing the same page twice. A combinational translate port looks up an address under the current process identifier so that installed entries can be checked.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After reset the three software registers read zero, `busy` is low, `utlb_inv` is low, every entry is empty and the translate port reports no hit.
- R2: Descriptor word 0 holds the ASID in bits 7:0, a global flag in bit 8, a valid flag in bit 9 and the virtual page number in bits 31:13 (8 KB pages). The set is taken from address bits 19:13. The linear index of set s, way w is s*WAYS+w.
- R3: Register writes use `reg_sel` 0 for word 0, 1 for word 1, 2 for the index register and 3 for the command register. A command write raises `busy` for exactly one cycle. Its result is visible after the second rising edge that follows. Register writes made while `busy` is high are ignored. Command codes are 1 probe, 2 get-index, 3 write, 4 write without invalidate, 5 read and 6 invalidate micro-TLBs. Other codes do nothing.
- R4: A probe that matches exactly one way loads the linear index of that way into the index register.
- R5: A probe that matches no way loads 32'h8000_0000. A probe that matches more than one way of the set loads 32'hC000_0000.
- R6: Get-index loads the linear index of the lowest-numbered way whose valid flag is clear, in the set selected by word 0.
- R7: When every way of that set is valid, get-index loads the way named by a per-set round-robin pointer, starting at way 0, and advances that pointer by one with wrap-around.
- R8: Write stores both descriptor registers into the entry named by the index register and pulses `utlb_inv` for one cycle. Write-without-invalidate stores the entry with no pulse. The invalidate command pulses `utlb_inv` and changes no register.
- R9: Read copies the entry named by the index register into both descriptor registers.
- R10: An entry matches only when its valid flag is set and its page number is equal. A non-global entry must also have an equal ASID: the ASID from word 0 for a probe, `cur_pid` for the translate port. A global entry matches under any ASID.
- R11: The translate port raises `lk_hit` and drives the stored second word of the lowest matching way in the set of `lk_vaddr`. It drives zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for the write |
| reg_wdata | input | 32 | Register write data |
| cur_pid | input | 8 | Current process identifier for translation |
| lk_vaddr | input | 32 | Translate-port virtual address |
| pd0_q | output | 32 | Descriptor word 0 register |
| pd1_q | output | 32 | Descriptor word 1 register |
| index_q | output | 32 | Index and lookup-result register |
| busy | output | 1 | Command in progress |
| utlb_inv | output | 1 | One-cycle micro-TLB invalidate pulse |
| lk_hit | output | 1 | Translate-port hit |
| lk_pd1 | output | 32 | Descriptor word 1 of the translate hit |

## Verification
The properties assume that software issues a command only while `busy` is low, and that `reset` is held across at least one edge. Under that assumption an accepted command, a one-cycle busy window and the timing of the invalidate pulse follow directly from the register strobes. The stimulus tasks always wait out the busy cycle before the next access. One directed sequence deliberately writes during `busy` to exercise the ignore rule. Random page numbers are drawn from a small pool over four sets. This forces probe hits that overwrite entries, full sets and round-robin replacement. Duplicates are made on purpose by explicit indexed writes in a separate set.

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine #(
  parameter int SETS      = 128,
  parameter int WAYS      = 4,
  parameter int PAGE_BITS = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic [7:0]  cur_pid,
  input  logic [31:0] lk_vaddr,
  output logic [31:0] pd0_q,
  output logic [31:0] pd1_q,
  output logic [31:0] index_q,
  output logic        busy,
  output logic        utlb_inv,
  output logic        lk_hit,
  output logic [31:0] lk_pd1
);
  localparam int SBITS   = $clog2(SETS);
  localparam int WBITS   = $clog2(WAYS);
  localparam int ENTRIES = SETS * WAYS;
  localparam int IBITS   = $clog2(ENTRIES);
  localparam int G_BIT   = 8;
  localparam int V_BIT   = 9;
  localparam logic [1:0]  SEL_PD0 = 2'd0, SEL_PD1 = 2'd1, SEL_IDX = 2'd2, SEL_CMD = 2'd3;
  localparam logic [2:0]  OP_PROBE = 3'd1, OP_GETIDX = 3'd2, OP_WRITE = 3'd3,
                          OP_WRITENI = 3'd4, OP_READ = 3'd5, OP_UINV = 3'd6;
  localparam logic [31:0] IDX_MISS = 32'h8000_0000;
  localparam logic [31:0] IDX_DUP  = 32'hC000_0000;

  logic [31:0]      pd0_mem [ENTRIES];
  logic [31:0]      pd1_mem [ENTRIES];
  logic [WBITS-1:0] rr      [SETS];
  logic [2:0]       op_q;

  function automatic logic hit_fn(input logic [31:0] e, input logic [31:0] va,
                                  input logic [7:0] asid);
    return e[V_BIT] && (e[31:PAGE_BITS] == va[31:PAGE_BITS]) &&
           (e[G_BIT] || (e[7:0] == asid));
  endfunction

  wire [SBITS-1:0] p_set = pd0_q[PAGE_BITS +: SBITS];
  wire [SBITS-1:0] l_set = lk_vaddr[PAGE_BITS +: SBITS];
  wire [IBITS-1:0] idx   = index_q[IBITS-1:0];

  logic [WAYS-1:0]  p_hit, p_free, l_hit;
  logic [WBITS-1:0] p_way, f_way, l_way;
  logic [WBITS:0]   p_cnt;

  always_comb begin
    p_hit  = '0;
    p_free = '0;
    l_hit  = '0;
    p_way  = '0;
    f_way  = '0;
    l_way  = '0;
    p_cnt  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      p_hit[w]  = hit_fn(pd0_mem[{p_set, WBITS'(w)}], pd0_q, pd0_q[7:0]);
      p_free[w] = !pd0_mem[{p_set, WBITS'(w)}][V_BIT];
      l_hit[w]  = hit_fn(pd0_mem[{l_set, WBITS'(w)}], lk_vaddr, cur_pid);
      p_cnt     = p_cnt + (WBITS+1)'(p_hit[w]);
      if (p_hit[w])  p_way = WBITS'(w);
      if (p_free[w]) f_way = WBITS'(w);
      if (l_hit[w])  l_way = WBITS'(w);
    end
  end

  assign lk_hit = |l_hit;
  assign lk_pd1 = lk_hit ? pd1_mem[{l_set, l_way}] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd0_q    <= '0;
      pd1_q    <= '0;
      index_q  <= '0;
      busy     <= 1'b0;
      utlb_inv <= 1'b0;
      op_q     <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pd0_mem[i] <= '0;
        pd1_mem[i] <= '0;
      end
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
    end else begin
      utlb_inv <= 1'b0;
      if (busy) begin
        busy <= 1'b0;
        case (op_q)
          OP_PROBE: begin
            if (p_cnt == '0)      index_q <= IDX_MISS;
            else if (p_cnt > 1)   index_q <= IDX_DUP;
            else                  index_q <= 32'({p_set, p_way});
          end
          OP_GETIDX: begin
            if (|p_free) index_q <= 32'({p_set, f_way});
            else begin
              index_q   <= 32'({p_set, rr[p_set]});
              rr[p_set] <= rr[p_set] + WBITS'(1);
            end
          end
          OP_WRITE, OP_WRITENI: begin
            pd0_mem[idx] <= pd0_q;
            pd1_mem[idx] <= pd1_q;
            utlb_inv     <= (op_q == OP_WRITE);
          end
          OP_READ: begin
            pd0_q <= pd0_mem[idx];
            pd1_q <= pd1_mem[idx];
          end
          OP_UINV: utlb_inv <= 1'b1;
          default: ;
        endcase
      end else if (reg_we) begin
        case (reg_sel)
          SEL_PD0: pd0_q   <= reg_wdata;
          SEL_PD1: pd1_q   <= reg_wdata;
          SEL_IDX: index_q <= reg_wdata;
          SEL_CMD: begin
            busy <= 1'b1;
            op_q <= reg_wdata[2:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlb_cmd_engine_chk.sv
module tlb_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic [31:0] pd0_q,
  input logic [31:0] pd1_q,
  input logic [31:0] index_q,
  input logic        busy,
  input logic        utlb_inv
);
  wire cmd_go  = reg_we && (reg_sel == 2'd3) && !busy;
  wire inv_cmd = (reg_wdata[2:0] == 3'd3) || (reg_wdata[2:0] == 3'd6);

  p_cmd_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> busy);
  p_busy_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_we) |=> ($stable(pd0_q) && $stable(pd1_q) && $stable(index_q)));
  p_inv_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && inv_cmd) |=> ##1 utlb_inv);
  p_no_inv_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !inv_cmd) |=> ##1 !utlb_inv);
  p_inv_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_inv |=> !utlb_inv);
endmodule

bind tlb_cmd_engine tlb_cmd_engine_chk u_chk (.*);

// File: tb/sim_tlb_cmd_engine.sv
module sim_tlb_cmd_engine;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, lk_vaddr = 0;
  logic [7:0] cur_pid = 0;
  logic [31:0] pd0_q, pd1_q, index_q, lk_pd1;
  logic busy, utlb_inv, lk_hit;

  tlb_cmd_engine u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] m0 [512];
  logic [31:0] m1 [512];
  logic [1:0]  mrr [128];
  logic [31:0] r_pd0 = 0, r_pd1 = 0, r_idx = 0;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic mhit(logic [31:0] e, logic [31:0] va, logic [7:0] a);
    return e[9] && e[31:13] == va[31:13] && (e[8] || e[7:0] == a);
  endfunction

  function automatic logic [31:0] m_probe(logic [31:0] p);
    int s = int'(p[19:13]);
    int cnt = 0, first = 0;
    for (int w = 3; w >= 0; w--)
      if (mhit(m0[s*4+w], p, p[7:0])) begin cnt++; first = w; end
    if (cnt == 0) return 32'h8000_0000;
    if (cnt > 1)  return 32'hC000_0000;
    return 32'(s*4 + first);
  endfunction

  task automatic m_getidx(logic [31:0] p, output logic [31:0] r);
    int s = int'(p[19:13]);
    int fw = -1;
    for (int w = 3; w >= 0; w--) if (!m0[s*4+w][9]) fw = w;
    if (fw >= 0) r = 32'(s*4 + fw);
    else begin
      r = 32'(s*4 + int'(mrr[s]));
      mrr[s] = mrr[s] + 2'd1;
    end
  endtask

  task automatic wreg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (sel == 0) r_pd0 = d;
    if (sel == 1) r_pd1 = d;
    if (sel == 2) r_idx = d;
  endtask

  task automatic docmd(logic [2:0] op, output logic inv);
    @(negedge clk);
    reg_we = 1; reg_sel = 2'd3; reg_wdata = 32'(op);
    @(negedge clk);
    reg_we = 0;
    check("R3 busy during command", 32'(busy), 32'd1);
    @(negedge clk);
    inv = utlb_inv;
    check("R3 busy released", 32'(busy), 32'd0);
  endtask

  task automatic probe_chk(string tag);
    logic inv;
    docmd(3'd1, inv);
    r_idx = m_probe(r_pd0);
    check(tag, index_q, r_idx);
  endtask

  task automatic insert(logic [31:0] p0, logic [31:0] p1);
    logic inv;
    logic [31:0] e;
    wreg(0, p0);
    probe_chk("R4/R5 probe before insert");
    if (r_idx[31]) begin
      docmd(3'd2, inv);
      m_getidx(p0, e);
      r_idx = e;
      check("R6/R7 get-index", index_q, e);
    end
    wreg(1, p1);
    docmd(3'd3, inv);
    check("R8 write pulses invalidate", 32'(inv), 32'd1);
    m0[r_idx[8:0]] = p0;
    m1[r_idx[8:0]] = p1;
  endtask

  task automatic lookup_chk(logic [31:0] va, logic [7:0] pid, string tag);
    logic [31:0] ep = 0;
    logic eh = 0;
    int s = int'(va[19:13]);
    @(negedge clk);
    lk_vaddr = va; cur_pid = pid;
    #1;
    for (int w = 3; w >= 0; w--)
      if (mhit(m0[s*4+w], va, pid)) begin eh = 1; ep = m1[s*4+w]; end
    check({tag, " hit"}, 32'(lk_hit), 32'(eh));
    check({tag, " data"}, lk_pd1, ep);
  endtask

  function automatic logic [31:0] mk(int vpn_hi, int set, logic v, logic g, logic [7:0] a);
    return (32'(vpn_hi) << 20) | (32'(set) << 13) | (32'(v) << 9) | (32'(g) << 8) | 32'(a);
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic inv;
    logic [31:0] p;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin m0[i] = 0; m1[i] = 0; end
    for (int s = 0; s < 128; s++) mrr[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pd0 reset", pd0_q, 0);
    check("R1 pd1 reset", pd1_q, 0);
    check("R1 index reset", index_q, 0);
    check("R1 busy reset", 32'(busy), 0);
    check("R1 inv reset", 32'(utlb_inv), 0);
    lookup_chk(32'h0000_0000, 8'h00, "R1 empty lookup");

    // R2/R6/R7: fill set 70, then round-robin replacement
    for (int k = 0; k < 6; k++) insert(mk(k + 1, 70, 1, 0, 8'h05), 32'hA000_0000 + 32'(k));
    check("R2 linear index of set 70 way 1", index_q, 32'd281);
    wreg(0, mk(3, 70, 1, 0, 8'h05));
    probe_chk("R4 probe hit in set 70");
    check("R4 probe index value", index_q, 32'd282);
    lookup_chk(mk(2, 70, 0, 0, 0), 8'h05, "R11 lookup replaced way");
    lookup_chk(mk(5, 70, 0, 0, 0), 8'h05, "R11 lookup rr way 0");
    lookup_chk(mk(5, 70, 0, 0, 0), 8'h06, "R10 asid mismatch");

    // R5: miss and duplicate
    wreg(0, mk(9, 90, 1, 0, 8'h01));
    probe_chk("R5 miss");
    check("R5 miss code", index_q, 32'h8000_0000);
    wreg(1, 32'h1111_2222);
    wreg(2, 32'd361);
    docmd(3'd4, inv);
    check("R8 write-ni no pulse", 32'(inv), 0);
    m0[361] = r_pd0; m1[361] = r_pd1;
    wreg(2, 32'd363);
    docmd(3'd4, inv);
    m0[363] = r_pd0; m1[363] = r_pd1;
    probe_chk("R5 duplicate");
    check("R5 duplicate code", index_q, 32'hC000_0000);

    // R9: read back
    wreg(2, 32'd282);
    wreg(0, 0); wreg(1, 0);
    docmd(3'd5, inv);
    check("R9 read pd0", pd0_q, m0[282]);
    check("R9 read pd1", pd1_q, m1[282]);

    // R10: global entry, invalid entry
    insert(mk(4, 91, 1, 1, 8'h11), 32'hBEEF_0001);
    lookup_chk(mk(4, 91, 0, 0, 0), 8'h22, "R10 global any pid");
    wreg(0, mk(4, 91, 1, 0, 8'h33));
    probe_chk("R10 global probe other asid");
    wreg(2, 32'd368);
    wreg(0, mk(6, 92, 0, 0, 8'h01));
    docmd(3'd4, inv);
    m0[368] = r_pd0; m1[368] = r_pd1;
    probe_chk("R10 invalid entry not matched");
    docmd(3'd2, inv);
    check("R6 invalid way counts as free", index_q, 32'd368);

    // R3: write while busy ignored; unknown op no effect
    @(negedge clk);
    reg_we = 1; reg_sel = 3; reg_wdata = 32'd6;
    @(negedge clk);
    reg_sel = 1; reg_wdata = 32'hDEAD_DEAD;
    @(negedge clk);
    reg_we = 0;
    check("R8 invalidate command pulse", 32'(utlb_inv), 1);
    check("R3 write during busy ignored", pd1_q, r_pd1);
    docmd(3'd7, inv);
    check("R3 unknown op index", index_q, 32'd368);
    check("R3 unknown op pd0", pd0_q, r_pd0);

    // random traffic over sets 0..3
    for (int it = 0; it < 400; it++) begin
      p = mk(int'($urandom % 4), int'($urandom % 4), ($urandom % 8) != 0,
             ($urandom % 6) == 0, 8'(1 + $urandom % 3));
      case ($urandom % 3)
        0: insert(p, $urandom);
        1: begin wreg(0, p); probe_chk("R4/R5 random probe"); end
        default: lookup_chk(p, 8'(1 + $urandom % 3), "R11 random lookup");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule